// File: doc/BRIEF.md
# HDLC Transmit Bit Stuffer with Selectable NRZ/NRZI Line Coding

This block turns a stream of bytes into the serial bit stream of an HDLC link. Between frames it repeats the 0x7E flag without pause. When a byte marked as the start of a frame arrives, the byte goes out after the end of the current flag. Bytes are shifted out least significant bit first. A zero is inserted into the frame body wherever five ones in a row have just been sent, so a receiver never mistakes payload for a flag. The byte marked as the end of the frame is followed by a closing flag, and that flag can also open the next frame.

A run-time configuration bit picks the line coding applied to the stuffed stream just before the output register. In NRZ mode the line carries the bit itself. In NRZI mode a zero toggles the line and a one leaves it unchanged. One bit is produced on each rising clock edge where the transmit clock enable is high. A frame is abandoned with a run of ones longer than any flag holds when an abort is requested, or when the next byte of an unfinished frame is not ready in time. The block then goes back to sending flags.

Top module: `hdlc_tx_stuffer`

## Requirements
- R1: While reset is held and after it is released, ser_out is 1 and in_ready stays low until the first enabled step; the flag sequence starts at its first bit.
- R2: With no frame pending, the raw stream is the flag 0x7E repeated, sent least significant bit first (bits 0,1,1,1,1,1,1,0), with no stuffing inside flags.
- R3: A byte with in_sof set is taken only on the last bit of a flag, and its first bit follows that flag; frame bytes go out least significant bit first; the byte with in_eof set is followed by a flag.
- R4: Within a frame body, a zero is inserted after every five consecutive ones, including across byte boundaries and after the final byte before the closing flag; the run count restarts at each flag.
- R5: With cfg_nrzi = 0, ser_out after an enabled step equals the stuffed bit of that step.
- R6: With cfg_nrzi = 1, an enabled step whose stuffed bit is 0 inverts ser_out and one whose bit is 1 keeps it; the mode may change between steps.
- R7: On clock edges where tx_ce is low, ser_out does not change and no byte is taken.
- R8: abort_req sampled high on an enabled step inside a frame ends the frame with at least seven consecutive ones, after which flags resume; abort_req outside a frame has no effect.
- R9: If the next byte of a frame that has not ended is not valid when the current byte's last bit is sent, the frame is aborted as in R8.
- R10: A valid byte without in_sof offered between frames is taken at a flag end and discarded, with no bits of it reaching the line.
- R11: in_ready is high only in a cycle where tx_ce is high, and a byte transfers on a rising edge where in_valid and in_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_ce | input | 1 | Transmit bit enable; one line bit per enabled edge |
| cfg_nrzi | input | 1 | Line coding select: 0 NRZ, 1 NRZI |
| abort_req | input | 1 | Request to abandon the frame in progress |
| in_data | input | BYTE_W | Byte to send, least significant bit first |
| in_valid | input | 1 | in_data, in_sof and in_eof are valid |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block takes the offered byte on this edge |
| ser_out | output | 1 | Registered serial line output |

## Verification
On every cycle the assertions check the line coder against the stuffed bit, for each mode. They also check that the line holds on edges without an enable, that in_ready appears only with the enable, and that the stuffed frame body never carries six ones in a row. Whether frames come out whole is shown only by the bench's scenarios. Its receiver removes stuffing, finds flags and aborts, and rebuilds bytes from the line. The scenarios cover byte values, frame lengths and byte patterns that force stuffing at a byte boundary or at the tail. They also cover abort, underrun and discarded bytes in both codings.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  // Sequencer phases of the transmit stream.
  typedef enum logic [1:0] {
    ST_FLAG  = 2'd0,  // sending a delimiter flag (idle or between frames)
    ST_DATA  = 2'd1,  // shifting frame bytes with zero insertion
    ST_DRAIN = 2'd2,  // one trailing stuffed zero before the closing flag
    ST_ABORT = 2'd3   // sending the run of ones that ends a frame early
  } tx_phase_e;
endpackage

// File: rtl/hdlc_tx_seq.sv
module hdlc_tx_seq
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned RUN_MAX    = 5,
  parameter int unsigned ABORT_ONES = 7,
  parameter logic [BYTE_W-1:0] FLAG_PAT = 8'h7E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              abort_req,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              raw_bit,
  output logic              body_bit
);
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int unsigned RUN_W = $clog2(RUN_MAX + 1);
  localparam int unsigned AB_W  = $clog2(ABORT_ONES + 1);
  localparam logic [CNT_W-1:0] IDX_LAST = CNT_W'(BYTE_W - 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_MAX);
  localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(RUN_MAX - 1);
  localparam logic [AB_W-1:0]  AB_FULL  = AB_W'(ABORT_ONES);
  localparam logic [AB_W-1:0]  AB_REST  = AB_W'(ABORT_ONES - 1);

  tx_phase_e         phase;
  logic [CNT_W-1:0]  bit_idx;
  logic [BYTE_W-1:0] shreg;
  logic              last_byte;
  logic [RUN_W-1:0]  run_cnt;
  logic [AB_W-1:0]   ab_left;

  logic in_body, abort_take, stuff_now, byte_end, flag_end, take;
  logic bit_c;

  always_comb begin
    in_body    = (phase == ST_DATA) || (phase == ST_DRAIN);
    abort_take = step && abort_req && in_body;
    stuff_now  = ((phase == ST_DATA) && (run_cnt == RUN_LAST)) || (phase == ST_DRAIN);
    byte_end   = (phase == ST_DATA) && !stuff_now && (bit_idx == IDX_LAST);
    flag_end   = (phase == ST_FLAG) && (bit_idx == IDX_LAST);
    in_ready   = step && !abort_take && (flag_end || (byte_end && !last_byte));
    take       = in_ready && in_valid;
    unique case (phase)
      ST_FLAG:  bit_c = FLAG_PAT[bit_idx];
      ST_DATA:  bit_c = stuff_now ? 1'b0 : shreg[0];
      ST_DRAIN: bit_c = 1'b0;
      default:  bit_c = 1'b1;
    endcase
    if (abort_take) bit_c = 1'b1;
    raw_bit  = bit_c;
    body_bit = in_body && !abort_take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= ST_FLAG;
      bit_idx   <= '0;
      shreg     <= '0;
      last_byte <= 1'b0;
      run_cnt   <= '0;
      ab_left   <= '0;
    end else if (step) begin
      if (abort_take) begin
        phase   <= ST_ABORT;
        ab_left <= AB_REST;
        run_cnt <= '0;
      end else begin
        unique case (phase)
          ST_FLAG: begin
            run_cnt <= '0;
            bit_idx <= flag_end ? '0 : bit_idx + 1'b1;
            if (take && in_sof) begin
              phase     <= ST_DATA;
              shreg     <= in_data;
              last_byte <= in_eof;
            end
          end
          ST_DATA: begin
            if (stuff_now) begin
              run_cnt <= '0;
            end else begin
              run_cnt <= shreg[0] ? run_cnt + 1'b1 : '0;
              shreg   <= shreg >> 1;
              if (byte_end) begin
                bit_idx <= '0;
                if (last_byte) begin
                  phase <= (shreg[0] && (run_cnt == RUN_PRE)) ? ST_DRAIN : ST_FLAG;
                end else if (take) begin
                  shreg     <= in_data;
                  last_byte <= in_eof;
                end else begin
                  phase   <= ST_ABORT;
                  ab_left <= AB_FULL;
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          ST_DRAIN: begin
            phase   <= ST_FLAG;
            bit_idx <= '0;
            run_cnt <= '0;
          end
          default: begin
            run_cnt <= '0;
            if (ab_left <= AB_W'(1)) begin
              phase   <= ST_FLAG;
              bit_idx <= '0;
            end else begin
              ab_left <= ab_left - 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic use_nrzi,
  input  logic raw_bit,
  output logic line_out
);
  // Registered line coder; the line rests high after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      line_out <= 1'b1;
    end else if (step) begin
      if (use_nrzi) line_out <= raw_bit ? line_out : ~line_out;
      else          line_out <= raw_bit;
    end
  end
endmodule

// File: rtl/hdlc_tx_stuffer.sv
module hdlc_tx_stuffer #(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned RUN_MAX    = 5,
  parameter int unsigned ABORT_ONES = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_ce,
  input  logic              cfg_nrzi,
  input  logic              abort_req,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  output logic              in_ready,
  output logic              ser_out
);
  localparam logic [BYTE_W-1:0] FLAG_PAT = BYTE_W'(8'h7E);

  logic raw_bit;
  logic body_bit;

  hdlc_tx_seq #(
    .BYTE_W    (BYTE_W),
    .RUN_MAX   (RUN_MAX),
    .ABORT_ONES(ABORT_ONES),
    .FLAG_PAT  (FLAG_PAT)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .step     (tx_ce),
    .abort_req(abort_req),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_sof   (in_sof),
    .in_eof   (in_eof),
    .in_ready (in_ready),
    .raw_bit  (raw_bit),
    .body_bit (body_bit)
  );

  hdlc_tx_line u_line (
    .clk     (clk),
    .rst     (rst),
    .step    (tx_ce),
    .use_nrzi(cfg_nrzi),
    .raw_bit (raw_bit),
    .line_out(ser_out)
  );
endmodule

// File: rtl/hdlc_tx_stuffer_chk.sv
module hdlc_tx_stuffer_chk #(
  parameter int unsigned RUN_MAX = 5
) (
  input logic clk,
  input logic rst,
  input logic tx_ce,
  input logic cfg_nrzi,
  input logic in_ready,
  input logic ser_out,
  input logic raw_bit,
  input logic body_bit
);
  logic [7:0] body_run;

  always_ff @(posedge clk) begin
    if (rst)        body_run <= '0;
    else if (tx_ce) body_run <= (body_bit && raw_bit) ? body_run + 1'b1 : '0;
  end

  // R1: the line rests high out of reset
  a_r1_line_high_after_reset: assert property (@(posedge clk)
    rst |=> ser_out);

  // R4: never six stuffed-body ones in a row
  a_r4_body_run_limit: assert property (@(posedge clk) disable iff (rst)
    body_run <= 8'(RUN_MAX));

  // R5: NRZ line follows the stuffed bit
  a_r5_nrz_follows_bit: assert property (@(posedge clk) disable iff (rst)
    (tx_ce && !cfg_nrzi) |=> (ser_out == $past(raw_bit)));

  // R6: NRZI zero toggles, one holds
  a_r6_nrzi_transition: assert property (@(posedge clk) disable iff (rst)
    (tx_ce && cfg_nrzi) |=> (ser_out == ($past(raw_bit) ? $past(ser_out) : !$past(ser_out))));

  // R7: no line change without an enable
  a_r7_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
    !tx_ce |=> $stable(ser_out));

  // R11: byte acceptance only on enabled steps
  a_r11_ready_needs_ce: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> tx_ce);
endmodule

bind hdlc_tx_stuffer hdlc_tx_stuffer_chk #(.RUN_MAX(RUN_MAX)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_ce   (tx_ce),
  .cfg_nrzi(cfg_nrzi),
  .in_ready(in_ready),
  .ser_out (ser_out),
  .raw_bit (raw_bit),
  .body_bit(body_bit)
);

// File: tb/tb_hdlc_tx_stuffer.sv
module tb_hdlc_tx_stuffer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_ce = 1'b0;
  logic       cfg_nrzi = 1'b0;
  logic       abort_req = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       in_sof = 1'b0;
  logic       in_eof = 1'b0;
  logic       in_ready;
  logic       ser_out;

  hdlc_tx_stuffer dut (
    .clk(clk), .rst(rst), .tx_ce(tx_ce), .cfg_nrzi(cfg_nrzi),
    .abort_req(abort_req), .in_data(in_data), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_ready(in_ready), .ser_out(ser_out)
  );

  always #2 clk = ~clk;  // 250 MHz

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Enable pattern: 0 = every cycle, 1 = two of three cycles, 2 = off
  int ce_mode = 2;
  int cyc = 0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tx_ce = (ce_mode == 0) ? 1'b1 : (ce_mode == 1) ? (cyc % 3 != 0) : 1'b0;
    end
  end

  // Expected frames
  logic [7:0] exp_mem [0:2047];
  int exp_base [0:127];
  int exp_len  [0:127];
  int n_exp = 0;
  int n_mem = 0;

  // Receiver model
  logic ce_q = 1'b0;
  logic nrzi_q = 1'b0;
  logic prev_line = 1'b1;
  int ones = 0;
  int nbits = 0;
  bit rbits [0:4095];
  int rx_frames = 0;
  int rx_aborts = 0;
  int raw_cnt = 0;
  bit raw_hist [0:15];

  always @(posedge clk) begin
    ce_q   <= tx_ce && !rst;
    nrzi_q <= cfg_nrzi;
  end

  always @(negedge clk) begin
    if (rst) begin
      prev_line = 1'b1;
      ones = 0;
      nbits = 0;
    end else if (!ce_q) begin
      chk(ser_out == prev_line, "R7", "line held without enable", ser_out, prev_line);
    end else begin
      bit b;
      b = nrzi_q ? (ser_out == prev_line) : ser_out;
      prev_line = ser_out;
      if (raw_cnt < 16) raw_hist[raw_cnt] = b;
      raw_cnt++;
      if (b) begin
        ones++;
        if (ones <= 5) begin
          if (nbits < 4096) rbits[nbits] = 1'b1;
          nbits++;
        end else if (ones == 6) begin
          nbits = (nbits >= 6) ? nbits - 6 : 0;
        end else if (ones == 7) begin
          rx_aborts++;
          nbits = 0;
        end
      end else begin
        if (ones == 6) begin
          if (nbits > 0) begin
            bit ok;
            int idx;
            idx = rx_frames;
            ok = (idx < n_exp) && (nbits == 8 * exp_len[idx]);
            if (ok) begin
              for (int k = 0; k < exp_len[idx]; k++) begin
                logic [7:0] by;
                for (int j = 0; j < 8; j++) by[j] = rbits[8 * k + j];
                if (by != exp_mem[exp_base[idx] + k]) ok = 0;
              end
            end
            chk(ok, nrzi_q ? "R3/R4/R6" : "R3/R4/R5", "frame bits rebuilt",
                nbits, (idx < n_exp) ? 8 * exp_len[idx] : -1);
            rx_frames++;
          end
          nbits = 0;
        end else if (ones < 5) begin
          if (nbits < 4096) rbits[nbits] = 1'b0;
          nbits++;
        end
        ones = 0;
      end
    end
  end

  task automatic send_byte(input logic [7:0] d, input bit sof, input bit eof);
    @(negedge clk);
    in_data = d; in_sof = sof; in_eof = eof; in_valid = 1'b1;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        #1 in_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic send_frame(input int len, input int salt, input int kind);
    exp_base[n_exp] = n_mem;
    exp_len[n_exp]  = len;
    for (int i = 0; i < len; i++) begin
      logic [7:0] v;
      if (kind == 1)      v = 8'(i);
      else if (kind == 2) v = (i % 2 == 0) ? 8'hF8 : 8'hFF;
      else                v = 8'((i * 29 + len * 53 + salt * 7) & 255);
      exp_mem[n_mem + i] = v;
    end
    n_mem += len;
    n_exp++;
    for (int i = 0; i < len; i++)
      send_byte(exp_mem[exp_base[n_exp-1] + i], i == 0, i == len - 1);
  endtask

  task automatic wait_rx();
    for (int k = 0; k < 3000 && rx_frames < n_exp; k++) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d frames", rx_frames, n_exp);
    finish_run();
  end

  initial begin
    int a0, f0;
    repeat (4) @(negedge clk);
    chk(ser_out == 1'b1, "R1", "ser_out in reset", ser_out, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(ser_out == 1'b1, "R1", "ser_out after reset, no enable", ser_out, 1);
    chk(in_ready == 1'b0, "R1", "in_ready without enable", in_ready, 0);

    // R2: idle flags, LSB first, NRZ
    ce_mode = 0;
    repeat (20) @(negedge clk);
    for (int i = 0; i < 16; i++)
      chk(raw_hist[i] == ((i % 8 == 0 || i % 8 == 7) ? 1'b0 : 1'b1),
          "R2", "idle flag bit", raw_hist[i], (i % 8 == 0 || i % 8 == 7) ? 0 : 1);

    // NRZ sweep, enable every cycle
    for (int L = 1; L <= 16; L++) send_frame(L, 0, 0);
    send_frame(256, 0, 1);
    send_frame(5, 0, 2);   // F8/FF mix: stuffing across bytes and at the tail
    send_frame(1, 0, 2);
    wait_rx();
    chk(rx_frames == n_exp, "R5", "NRZ frames received", rx_frames, n_exp);

    // NRZI sweep, sparse enable
    cfg_nrzi = 1'b1;
    ce_mode = 1;
    repeat (30) @(negedge clk);
    for (int L = 1; L <= 16; L++) send_frame(L, 1, 0);
    send_frame(256, 1, 1);
    send_frame(6, 1, 2);
    wait_rx();
    chk(rx_frames == n_exp, "R6", "NRZI frames received", rx_frames, n_exp);

    // R8: abort in the middle of a frame
    ce_mode = 0;
    a0 = rx_aborts; f0 = rx_frames;
    send_byte(8'h3C, 1, 0);
    send_byte(8'hA5, 0, 0);
    repeat (2) @(negedge clk);
    abort_req = 1'b1;
    repeat (3) @(negedge clk);
    abort_req = 1'b0;
    repeat (60) @(negedge clk);
    chk(rx_aborts == a0 + 1, "R8", "abort run seen", rx_aborts, a0 + 1);
    chk(rx_frames == f0, "R8", "aborted frame not delivered", rx_frames, f0);
    send_frame(3, 2, 0);
    wait_rx();
    chk(rx_frames == n_exp, "R8", "frame after abort", rx_frames, n_exp);

    // R8: abort request while idle is ignored
    a0 = rx_aborts; f0 = rx_frames;
    abort_req = 1'b1;
    repeat (40) @(negedge clk);
    abort_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(rx_aborts == a0, "R8", "idle abort ignored", rx_aborts, a0);
    chk(rx_frames == f0, "R8", "idle abort no frame", rx_frames, f0);

    // R9: underrun inside a frame
    a0 = rx_aborts; f0 = rx_frames;
    send_byte(8'h55, 1, 0);
    repeat (60) @(negedge clk);
    chk(rx_aborts == a0 + 1, "R9", "underrun aborts", rx_aborts, a0 + 1);
    chk(rx_frames == f0, "R9", "underrun no frame", rx_frames, f0);

    // R10: byte without start marker between frames is dropped
    a0 = rx_aborts; f0 = rx_frames;
    send_byte(8'h00, 0, 1);
    repeat (60) @(negedge clk);
    chk(rx_frames == f0, "R10", "stray byte no frame", rx_frames, f0);
    chk(rx_aborts == a0, "R10", "stray byte no abort", rx_aborts, a0);
    send_frame(2, 3, 0);
    wait_rx();
    chk(rx_frames == n_exp, "R10", "frame after stray byte", rx_frames, n_exp);

    finish_run();
  end
endmodule